// File: doc/BRIEF.md
# Sideband Message Bus Bridge

This block lets a host reach registers that live behind an internal, port-addressed register bus. The host sees just two 32-bit registers: a command register at offset 0xD0 and a data register at offset 0xD4. A host write to the command register is the only way to start a transaction. The bridge decodes four fields from the written word: opcode, target port, target register offset and byte enables. It then issues one request downstream.

For a write, the host first loads the data register and then writes the command word. The bridge sends the staged data to the target. For a read, the host writes the command word and waits for the busy flag to drop. The data register then holds the target's reply, with the disabled byte lanes cleared.

The downstream side uses two valid/ready handshakes, one for the request and one for the response. The bridge holds one transaction at a time.

Top module: `sbmb_bridge`

## Requirements
- R1: After a synchronous active-low reset, both host registers read 0, `host_busy` is low, and no downstream request is raised until a legal command word is written.
- R2: A host write to offset 0xD4 loads the data register. It reads back on `host_rdata` from the next cycle onward. This is true in every state, unless a read response is stored in the same cycle; then the response wins.
- R3: While idle, a host write to 0xD0 with opcode 0xE0 (write) or 0xD0 (read) in bits [31:24] does four things. It stores the word in the command register. It raises `dn_req_valid` and `host_busy` on the next cycle. It presents bits [23:16] as the port, [15:8] as the register offset and [7:4] as the byte enables. It also presents the data register content from the launch cycle as write data, with `dn_req_write` high only for opcode 0xE0.
- R4: When the response of a read transaction is accepted, the data register takes the returned word with every byte lane i whose enable bit i is clear forced to zero. The new value is visible the next cycle.
- R5: While `dn_req_valid` is high and `dn_req_ready` is low, the request stays raised and all its fields stay unchanged. The request drops on the cycle after it is accepted.
- R6: A command word whose opcode is neither 0xD0 nor 0xE0 starts no request and leaves busy low. It also leaves both host registers unchanged.
- R7: A write to the command register while busy is ignored. The command register keeps its value, and no second request follows the current one.
- R8: `host_busy` is high from the cycle after the launching write until the cycle after the response handshake. `dn_rsp_ready` is high exactly while the bridge waits for a response.
- R9: The response to a write transaction leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset (0xD0 command, 0xD4 data) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational readback of the addressed host register |
| host_busy | output | 1 | A transaction is in flight |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | Request is a write (1) or a read (0) |
| dn_req_port | output | 8 | Target port |
| dn_req_reg | output | 8 | Target register offset |
| dn_req_be | output | 4 | Byte-lane enables |
| dn_req_wdata | output | 32 | Write data staged in the data register |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Bridge waits for a response |
| dn_rsp_rdata | input | 32 | Response data (used for reads) |

## Verification
Each launching command write shows up one cycle later as raised busy and request valid. A request handshake turns into response-ready one cycle later. A response handshake clears busy and, for a read, updates the data register one cycle later. Host readback is combinational from the current offset.

The bench keeps a behavioural model that steps on every rising edge with the same inputs. A quarter period after each edge it compares busy, the request fields, response-ready and readback against the model. Directed checks then read the registers at the cycle each result is due: after reset, after an illegal opcode, after a write-response and a masked read-response, and after a command written while busy.

// File: rtl/sbmb_pkg.sv
// Package: shared constants, command fields and state encoding for the
// sideband message bus bridge. Assumes a 32-bit host word with 8-bit lanes.
package sbmb_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int LANE_W    = 8;
    localparam int LANES     = DATA_W / LANE_W;
    localparam int OPC_W     = 8;
    localparam int PORT_W    = 8;
    localparam int ROFF_W    = 8;
    localparam int RSVD_W    = 4;
    localparam int OPC_LSB   = DATA_W - OPC_W;
    localparam int PORT_LSB  = OPC_LSB - PORT_W;
    localparam int ROFF_LSB  = PORT_LSB - ROFF_W;
    localparam int BE_LSB    = ROFF_LSB - LANES;

    localparam logic [ADDR_W-1:0] CMD_OFFSET  = 8'hD0;
    localparam logic [ADDR_W-1:0] DATA_OFFSET = 8'hD4;
    localparam logic [OPC_W-1:0]  OPC_READ    = 8'hD0;
    localparam logic [OPC_W-1:0]  OPC_WRITE   = 8'hE0;

    typedef struct packed {
        logic              write;
        logic [PORT_W-1:0] port;
        logic [ROFF_W-1:0] roff;
        logic [LANES-1:0]  be;
    } sbmb_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2
    } sbmb_state_e;
endpackage

// File: rtl/sbmb_cmd_decode.sv
// Command decoder: splits a command word (reserved low bits excluded) into
// opcode, port, register offset and byte enables, and flags legal opcodes.
// Assumes the field layout held in sbmb_pkg.
module sbmb_cmd_decode
    import sbmb_pkg::*;
(
    input  logic [DATA_W-1:RSVD_W] cmd_word,
    output sbmb_cmd_t              cmd,
    output logic                   legal
);
    logic [OPC_W-1:0] opcode;

    // Field extraction and opcode classification
    always_comb begin
        opcode    = cmd_word[OPC_LSB +: OPC_W];
        cmd.write = (opcode == OPC_WRITE);
        cmd.port  = cmd_word[PORT_LSB +: PORT_W];
        cmd.roff  = cmd_word[ROFF_LSB +: ROFF_W];
        cmd.be    = cmd_word[BE_LSB +: LANES];
        legal     = (opcode == OPC_WRITE) || (opcode == OPC_READ);
    end
endmodule

// File: rtl/sbmb_lane_mask.sv
// Lane mask: clears every byte lane of a word whose enable bit is low.
// Assumes LANES * LANE_W equals the word width.
module sbmb_lane_mask #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int WIDTH = LANE_W * LANES
) (
    input  logic [WIDTH-1:0] din,
    input  logic [LANES-1:0] be,
    output logic [WIDTH-1:0] dout
);
    // One mask stage per lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = be[i] ? din[i*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sbmb_seq.sv
// Transaction sequencer: idle -> request -> response -> idle. Assumes launch
// is only asserted while idle; the response is awaited for reads and writes.
module sbmb_seq
    import sbmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic busy,
    output logic req_valid,
    output logic rsp_ready,
    output logic rsp_take
);
    sbmb_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)    state_d = ST_REQ;
            ST_REQ:  if (req_ready) state_d = ST_RSP;
            ST_RSP:  if (rsp_valid) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Handshake outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        req_valid = (state_q == ST_REQ);
        rsp_ready = (state_q == ST_RSP);
        rsp_take  = rsp_ready && rsp_valid;
    end
endmodule

// File: rtl/sbmb_bridge.sv
// Sideband message bus bridge: a host command register write launches one
// downstream transaction, using a staged data register for writes and
// returning read data into it. Assumes one transaction in flight.
module sbmb_bridge
    import sbmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_busy,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [PORT_W-1:0] dn_req_port,
    output logic [ROFF_W-1:0] dn_req_reg,
    output logic [LANES-1:0]  dn_req_be,
    output logic [DATA_W-1:0] dn_req_wdata,
    input  logic              dn_rsp_valid,
    output logic              dn_rsp_ready,
    input  logic [DATA_W-1:0] dn_rsp_rdata
);
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rsp_masked;
    sbmb_cmd_t         cmd_dec;
    sbmb_cmd_t         cur_q;
    logic              cmd_legal;
    logic              cmd_wr;
    logic              data_wr;
    logic              launch;
    logic              rsp_take;

    // Host write decode
    always_comb begin
        cmd_wr  = host_wr_en && (host_addr == CMD_OFFSET);
        data_wr = host_wr_en && (host_addr == DATA_OFFSET);
        launch  = cmd_wr && cmd_legal && !host_busy;
    end

    sbmb_cmd_decode u_dec (
        .cmd_word (host_wdata[DATA_W-1:RSVD_W]),
        .cmd      (cmd_dec),
        .legal    (cmd_legal)
    );

    sbmb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .req_ready (dn_req_ready),
        .rsp_valid (dn_rsp_valid),
        .busy      (host_busy),
        .req_valid (dn_req_valid),
        .rsp_ready (dn_rsp_ready),
        .rsp_take  (rsp_take)
    );

    sbmb_lane_mask #(.LANE_W(LANE_W), .LANES(LANES)) u_mask (
        .din  (dn_rsp_rdata),
        .be   (cur_q.be),
        .dout (rsp_masked)
    );

    // Command register and in-flight command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            cur_q   <= '0;
            wdata_q <= '0;
        end else if (launch) begin
            cmd_q   <= host_wdata;
            cur_q   <= cmd_dec;
            wdata_q <= data_q;
        end
    end

    // Data register: read response has priority over a host load
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (rsp_take && !cur_q.write) data_q <= rsp_masked;
        else if (data_wr)                data_q <= host_wdata;
    end

    // Host readback mux
    always_comb begin
        if (host_addr == CMD_OFFSET)       host_rdata = cmd_q;
        else if (host_addr == DATA_OFFSET) host_rdata = data_q;
        else                               host_rdata = '0;
    end

    // Downstream request fields
    always_comb begin
        dn_req_write = cur_q.write;
        dn_req_port  = cur_q.port;
        dn_req_reg   = cur_q.roff;
        dn_req_be    = cur_q.be;
        dn_req_wdata = wdata_q;
    end
endmodule

// File: rtl/sbmb_bridge_chk.sv
// Checker for sbmb_bridge: handshake and sequencing properties, bound to
// every instance of the top module.
module sbmb_bridge_chk
    import sbmb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_busy,
    input logic              dn_req_valid,
    input logic              dn_req_ready,
    input logic              dn_req_write,
    input logic [PORT_W-1:0] dn_req_port,
    input logic [ROFF_W-1:0] dn_req_reg,
    input logic [LANES-1:0]  dn_req_be,
    input logic [DATA_W-1:0] dn_req_wdata,
    input logic              dn_rsp_valid,
    input logic              dn_rsp_ready,
    input logic [DATA_W-1:0] data_q
);
    logic cmd_wr, legal_op;
    assign cmd_wr   = host_wr_en && (host_addr == CMD_OFFSET);
    assign legal_op = (host_wdata[OPC_LSB +: OPC_W] == OPC_READ) ||
                      (host_wdata[OPC_LSB +: OPC_W] == OPC_WRITE);

    AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy && cmd_wr && legal_op) |=> (dn_req_valid && host_busy)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid &&
        $stable({dn_req_write, dn_req_port, dn_req_reg, dn_req_be, dn_req_wdata}))); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_ready) |=> (!dn_req_valid && dn_rsp_ready)); // R5
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_busy && cmd_wr && !legal_op) |=> !host_busy); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> (!dn_req_valid && !dn_rsp_ready)); // R8
    AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rsp_valid && dn_rsp_ready) |=> !host_busy); // R8
    AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rsp_valid && dn_rsp_ready && dn_req_write &&
         !(host_wr_en && host_addr == DATA_OFFSET)) |=> $stable(data_q)); // R9
endmodule

bind sbmb_bridge sbmb_bridge_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_busy    (host_busy),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_port  (dn_req_port),
    .dn_req_reg   (dn_req_reg),
    .dn_req_be    (dn_req_be),
    .dn_req_wdata (dn_req_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_ready (dn_rsp_ready),
    .data_q       (data_q)
);

// File: tb/sbmb_bridge_tb_top.sv
// Bench: behavioural model stepped per clock plus directed checks.
module sbmb_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = 8'hD0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_busy;
    logic        dn_req_valid, dn_req_ready = 1'b0;
    logic        dn_req_write;
    logic [7:0]  dn_req_port, dn_req_reg;
    logic [3:0]  dn_req_be;
    logic [31:0] dn_req_wdata;
    logic        dn_rsp_valid = 1'b0, dn_rsp_ready;
    logic [31:0] dn_rsp_rdata = '0;

    int tests = 0, fails = 0, cycles = 0, req_count = 0;

    sbmb_bridge dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int          m_phase = 0;
    logic [31:0] m_cmd = '0, m_data = '0, m_wdata = '0;
    logic        m_write = 1'b0;
    logic [7:0]  m_port = '0, m_reg = '0;
    logic [3:0]  m_be = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model step on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cmd = '0; m_data = '0; m_wdata = '0;
            m_write = 0; m_port = '0; m_reg = '0; m_be = '0;
        end else begin
            if (dn_req_valid && dn_req_ready) req_count++;
            case (m_phase)
                0: begin
                    if (host_wr_en && host_addr == 8'hD0 &&
                        (host_wdata[31:24] == 8'hD0 || host_wdata[31:24] == 8'hE0)) begin
                        m_cmd   = host_wdata;
                        m_write = (host_wdata[31:24] == 8'hE0);
                        m_port  = host_wdata[23:16];
                        m_reg   = host_wdata[15:8];
                        m_be    = host_wdata[7:4];
                        m_wdata = m_data;
                        m_phase = 1;
                    end else if (host_wr_en && host_addr == 8'hD4) m_data = host_wdata;
                end
                1: begin
                    if (host_wr_en && host_addr == 8'hD4) m_data = host_wdata;
                    if (dn_req_ready) m_phase = 2;
                end
                default: begin
                    if (dn_rsp_valid && !m_write) begin
                        for (int i = 0; i < 4; i++)
                            m_data[i*8 +: 8] = m_be[i] ? dn_rsp_rdata[i*8 +: 8] : 8'h00;
                    end else if (host_wr_en && host_addr == 8'hD4) m_data = host_wdata;
                    if (dn_rsp_valid) m_phase = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison a quarter period after each edge
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (rst_n) begin
            check("R8 busy", {31'd0, host_busy}, {31'd0, m_phase != 0});
            check("R5 req_valid", {31'd0, dn_req_valid}, {31'd0, m_phase == 1});
            check("R8 rsp_ready", {31'd0, dn_rsp_ready}, {31'd0, m_phase == 2});
            check("R2 rdata", host_rdata,
                  host_addr == 8'hD0 ? m_cmd : host_addr == 8'hD4 ? m_data : 32'd0);
            if (m_phase == 1) begin
                check("R3 write", {31'd0, dn_req_write}, {31'd0, m_write});
                check("R3 fields", {8'd0, dn_req_port, dn_req_reg, 4'd0, dn_req_be},
                      {8'd0, m_port, m_reg, 4'd0, m_be});
                check("R3 wdata", dn_req_wdata, m_wdata);
            end
        end
    end

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic serve(input int rdy_wait, input int rsp_wait, input logic [31:0] rd);
        while (!dn_req_valid) @(negedge clk);
        repeat (rdy_wait) @(negedge clk);
        dn_req_ready = 1'b1;
        @(negedge clk);
        dn_req_ready = 1'b0;
        repeat (rsp_wait) @(negedge clk);
        dn_rsp_valid = 1'b1; dn_rsp_rdata = rd;
        @(negedge clk);
        dn_rsp_valid = 1'b0; dn_rsp_rdata = 32'hDEAD_BEEF;
    endtask

    task automatic peek(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek("R1 cmd after reset", 8'hD0, 32'h0);
        peek("R1 data after reset", 8'hD4, 32'h0);
        check("R1 busy", {31'd0, host_busy}, 32'd0);
        check("R1 req_valid", {31'd0, dn_req_valid}, 32'd0);

        // R2 data load
        host_write(8'hD4, 32'hCAFE_F00D);
        peek("R2 data load", 8'hD4, 32'hCAFE_F00D);

        // R3/R9 write transaction with stalled ready
        host_write(8'hD0, 32'hE003_12F0);
        check("R3 launch valid", {31'd0, dn_req_valid}, 32'd1);
        check("R3 wdata", dn_req_wdata, 32'hCAFE_F00D);
        serve(3, 2, 32'h1234_5678);
        peek("R9 data kept", 8'hD4, 32'hCAFE_F00D);
        check("R8 idle after rsp", {31'd0, host_busy}, 32'd0);

        // R4 full read
        host_write(8'hD0, 32'hD003_10F0);
        check("R3 read dir", {31'd0, dn_req_write}, 32'd0);
        serve(0, 0, 32'hA5A5_5A5A);
        peek("R4 full read", 8'hD4, 32'hA5A5_5A5A);

        // R4 masked read, lanes 0 and 2
        host_write(8'hD0, 32'hD007_2250);
        serve(1, 3, 32'hFFFF_FFFF);
        peek("R4 masked read", 8'hD4, 32'h00FF_00FF);

        // R6 illegal opcode
        req_count = 0;
        host_write(8'hD0, 32'h7703_10F0);
        repeat (3) @(negedge clk);
        check("R6 no request", req_count, 0);
        check("R6 not busy", {31'd0, host_busy}, 32'd0);
        peek("R6 cmd kept", 8'hD0, 32'hD007_2250);
        peek("R6 data kept", 8'hD4, 32'h00FF_00FF);

        // R7 command while busy, partial enables on write
        req_count = 0;
        host_write(8'hD4, 32'h0BAD_CAFE);
        host_write(8'hD0, 32'hE011_4430);
        host_write(8'hD0, 32'hD022_55F0);
        peek("R7 cmd unchanged", 8'hD0, 32'hE011_4430);
        serve(0, 1, 32'h0);
        repeat (4) @(negedge clk);
        check("R7 single request", req_count, 1);
        peek("R7 data kept", 8'hD4, 32'h0BAD_CAFE);

        // R2 data write while busy is accepted
        host_write(8'hD0, 32'hE001_01F0);
        host_write(8'hD4, 32'h5555_AAAA);
        serve(2, 0, 32'h0);
        peek("R2 load while busy", 8'hD4, 32'h5555_AAAA);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule